// File: doc/BRIEF.md
# Segmented Physical Address Unit

This block keeps the four segment base registers of a 16-bit segmented processor and turns an effective offset into a 20-bit physical address. The address generator supplies the offset and a flag that says whether the offset was built from the BP base register. The block picks a segment register, shifts its value left by four bits, adds the offset, and drives both the chosen segment code and the physical address combinationally in the same cycle.

The block watches the fetched byte stream for segment-override prefix bytes. A recognised prefix arms an override that replaces the default segment choice. An end-of-instruction strobe disarms it, so the override covers only the one instruction that follows the prefix. Software loads the segment registers through a single write port. Bus cycles, full instruction decode and protection checks are handled elsewhere.

Top module: `phys_addr_unit`

## Requirements
- R1: After reset every segment register holds zero and no override is armed, so `physAddr` equals `offset` and `segSel` follows the default rule.
- R2: A cycle with `wrEn` high loads `wrData` into the register coded by `wrSel` (0 = ES, 1 = CS, 2 = SS, 3 = DS). The new value is visible from the next cycle. With `wrEn` low, no register changes.
- R3: `physAddr` equals (selected segment value × 16 + `offset`) modulo 2^20, combinationally.
- R4: With no override armed, `segSel` is 2 (SS) when `bpBased` is 1 and 3 (DS) when `bpBased` is 0.
- R5: A byte with `byteValid` high and a value of the form 001ss110 (0x26, 0x2E, 0x36, 0x3E) arms an override for segment code ss (bits 4:3) from the next cycle. Every other byte value leaves the selection unchanged.
- R6: An armed override stays in force over any number of cycles until `instEnd` is high at a clock edge. From the cycle after that edge, the default rule applies again.
- R7: When several prefix bytes arrive before `instEnd`, the last one decides the segment. Non-prefix bytes in between do not cancel it.
- R8: A prefix byte in the same cycle as `instEnd` leaves the override armed with that prefix's segment.
- R9: While an override is armed, `bpBased` has no effect on `segSel` or `physAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Segment register write strobe |
| wrSel | input | 2 | Segment code to write (0 ES, 1 CS, 2 SS, 3 DS) |
| wrData | input | SEG_W | Value to write |
| byteValid | input | 1 | `byteData` carries a fetched instruction byte |
| byteData | input | 8 | Fetched byte, checked for an override prefix |
| instEnd | input | 1 | Last cycle of the current instruction |
| offset | input | OFS_W | Effective offset from the address generator |
| bpBased | input | 1 | The offset uses BP as its base |
| segSel | output | 2 | Segment code in use |
| physAddr | output | SEG_W+SEG_SHIFT | Physical address |

## Verification
The bench uses the default parameters: 16-bit segment values, 16-bit offsets and a 4-bit shift, which give a 20-bit address. This size lets it try all 256 byte values as prefix candidates, each followed by an end strobe. It also runs a 16 by 16 grid of segment and offset values that reaches the carry out of bit 19, where the address wraps. The same small size covers every combination of armed segment and `bpBased`, and the prefix orderings: last prefix wins, a non-prefix byte in between, and a prefix in the same cycle as the end strobe.

// File: rtl/pau_pkg.sv
package pau_pkg;

  localparam int SEG_COUNT = 4;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_code_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      wrStb;
    seg_code_e wrIdx;
    seg_code_e rdIdx;
  } pau_ctl_t;

  // override prefix pattern: 001ss110
  localparam logic [7:0] PREFIX_MASK  = 8'hE7;
  localparam logic [7:0] PREFIX_MATCH = 8'h26;

endpackage

// File: rtl/pau_ctrl.sv
module pau_ctrl
  import pau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       byteValid,
  input  logic [7:0] byteData,
  input  logic       instEnd,
  input  logic       bpBased,
  output pau_ctl_t   ctl
);

  logic      prefixHit;
  logic      pendValid;
  seg_code_e pendSeg;
  seg_code_e defaultSeg;

  assign prefixHit = byteValid && ((byteData & PREFIX_MASK) == PREFIX_MATCH);

  // a new prefix outranks the end strobe: it belongs to the next instruction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendSeg   <= SEG_ES;
    end else if (prefixHit) begin
      pendValid <= 1'b1;
      pendSeg   <= seg_code_e'(byteData[4:3]);
    end else if (instEnd) begin
      pendValid <= 1'b0;
    end
  end

  assign defaultSeg = bpBased ? SEG_SS : SEG_DS;

  always_comb begin
    ctl.wrStb = wrEn;
    ctl.wrIdx = seg_code_e'(wrSel);
    ctl.rdIdx = pendValid ? pendSeg : defaultSeg;
  end

  // R5: a prefix byte arms its segment
  a_r5_prefix_arms: assert property (@(posedge clk) disable iff (!rstN)
    prefixHit |=> (pendValid && pendSeg == seg_code_e'($past(byteData[4:3]))));

  // R6: end strobe without a new prefix disarms
  a_r6_end_clears: assert property (@(posedge clk) disable iff (!rstN)
    (instEnd && !prefixHit) |=> !pendValid);

  // R6/R7: armed state holds when nothing touches it
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !instEnd && !prefixHit) |=> (pendValid && $stable(pendSeg)));

  // R5: non-prefix bytes never arm
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!pendValid && !prefixHit) |=> !pendValid);

endmodule

// File: rtl/pau_datapath.sv
module pau_datapath
  import pau_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
)(
  input  logic              clk,
  input  logic              rstN,
  input  pau_ctl_t          ctl,
  input  logic [SEG_W-1:0]  wrData,
  input  logic [OFS_W-1:0]  offset,
  output logic [ADDR_W-1:0] physAddr
);

  logic [SEG_W-1:0]  segReg [SEG_COUNT];
  logic [SEG_W-1:0]  selSeg;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] ofsExt;

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN)
        segReg[g] <= '0;
      else if (ctl.wrStb && ctl.wrIdx == seg_code_e'(g))
        segReg[g] <= wrData;
    end

    // R2: untouched registers keep their value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(ctl.wrStb && ctl.wrIdx == seg_code_e'(g)) |=> $stable(segReg[g]));
  end

  assign selSeg   = segReg[ctl.rdIdx];
  assign baseAddr = {selSeg, {SEG_SHIFT{1'b0}}};
  assign ofsExt   = ADDR_W'(offset);
  assign physAddr = baseAddr + ofsExt;   // carry out of the top drops: wrap

  // R2: written value lands in the addressed register
  a_r2_write: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrStb |=> (segReg[$past(ctl.wrIdx)] == $past(wrData)));

  // R3: the low bits below the shift come straight from the offset
  a_r3_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[SEG_SHIFT-1:0] == offset[SEG_SHIFT-1:0]);

endmodule

// File: rtl/phys_addr_unit.sv
module phys_addr_unit
  import pau_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int ADDR_W   = SEG_W + SEG_SHIFT
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [SEG_W-1:0]  wrData,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              instEnd,
  input  logic [OFS_W-1:0]  offset,
  input  logic              bpBased,
  output logic [1:0]        segSel,
  output logic [ADDR_W-1:0] physAddr
);

  pau_ctl_t ctl;

  pau_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .byteValid (byteValid),
    .byteData  (byteData),
    .instEnd   (instEnd),
    .bpBased   (bpBased),
    .ctl       (ctl)
  );

  pau_datapath #(
    .SEG_W     (SEG_W),
    .OFS_W     (OFS_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (wrData),
    .offset   (offset),
    .physAddr (physAddr)
  );

  assign segSel = ctl.rdIdx;

endmodule

// File: tb/phys_addr_unit_bench.sv
module phys_addr_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        instEnd = 1'b0;
  logic [15:0] offset = '0;
  logic        bpBased = 1'b0;
  logic [1:0]  segSel;
  logic [19:0] physAddr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  int segModel [4];
  bit pendV = 0;
  int pendS = 0;

  always #4 clk = ~clk;

  phys_addr_unit u_phys_addr_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .byteValid(byteValid), .byteData(byteData), .instEnd(instEnd),
    .offset(offset), .bpBased(bpBased), .segSel(segSel), .physAddr(physAddr)
  );

  function automatic int addrOf(int seg, int ofs);
    return ((seg << 4) + ofs) & 32'hFFFFF;
  endfunction

  function automatic bit isPrefix(int b);
    return (b & 8'hE7) == 8'h26;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag);
    int es;
    #1;
    es = pendV ? pendS : (bpBased ? 2 : 3);
    chk({tag, " seg"}, int'(segSel), es);
    chk({tag, " addr"}, int'(physAddr), addrOf(segModel[es], int'(offset)));
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int val);
    wrEn = 1'b1; wrSel = 2'(idx); wrData = 16'(val);
    cycle();
    wrEn = 1'b0;
    segModel[idx] = val;
  endtask

  task automatic feed(input int b);
    byteValid = 1'b1; byteData = 8'(b);
    cycle();
    byteValid = 1'b0;
    if (isPrefix(b)) begin pendV = 1; pendS = (b >> 3) & 3; end
  endtask

  task automatic endInst();
    instEnd = 1'b1;
    cycle();
    instEnd = 1'b0;
    pendV = 0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) segModel[i] = 0;
    repeat (3) cycle();
    rstN = 1'b1;

    // R1: reset state, offset passes straight through
    offset = 16'hBEEF; bpBased = 1'b0; checkOut("R1 reset ds");
    bpBased = 1'b1; checkOut("R1 reset ss");
    offset = 16'hFFFF; checkOut("R1 reset top");

    // R2: write each register, observe via override
    wr(0, 16'h1234); wr(1, 16'hF000); wr(2, 16'h0800); wr(3, 16'hFFFF);
    for (int s = 0; s < 4; s++) begin
      feed(8'h26 | (s << 3));
      offset = 16'h0010; checkOut("R2 readback");
      endInst();
    end
    // R2: wrEn low leaves registers alone
    wrData = 16'h5555; wrSel = 2'd3;
    cycle();
    offset = 16'h0001; bpBased = 1'b0; checkOut("R2 no write");

    // R4: default selection
    bpBased = 1'b1; checkOut("R4 bp ss");
    bpBased = 1'b0; checkOut("R4 nobp ds");

    // R5/R6: every byte value as a prefix candidate
    for (int b = 0; b < 256; b++) begin
      feed(b);
      offset = 16'(b * 257); bpBased = 1'b0;
      checkOut("R5 byte sweep");
      endInst();
      checkOut("R6 cleared");
    end

    // R3: segment/offset grid through the wrap point (DS, default path)
    for (int i = 0; i < 16; i++) begin
      wr(3, i * 16'h1111);
      for (int j = 0; j < 16; j++) begin
        offset = 16'(j * 16'h1111); bpBased = 1'b0;
        checkOut("R3 grid");
      end
    end
    offset = 16'hFFFF; #1;
    chk("R3 wrap", int'(physAddr), 32'h0FFEF);

    // R6: override persists across idle cycles
    feed(8'h2E);
    for (int k = 0; k < 5; k++) begin
      cycle();
      checkOut("R6 persist");
    end
    endInst();
    checkOut("R6 after end");

    // R7: last prefix wins, non-prefix does not cancel
    feed(8'h26); feed(8'h36);
    checkOut("R7 last wins");
    feed(8'h90);
    checkOut("R7 nonprefix kept");
    feed(8'h3E); feed(8'h2E);
    #1; chk("R7 cs", int'(segSel), 1);
    endInst();

    // R8: prefix and end strobe in the same cycle
    feed(8'h26);
    byteValid = 1'b1; byteData = 8'h36; instEnd = 1'b1;
    cycle();
    byteValid = 1'b0; instEnd = 1'b0;
    pendV = 1; pendS = 2;
    bpBased = 1'b0; checkOut("R8 prefix beats end");
    endInst();

    // R9: bpBased ignored under override
    feed(8'h3E);
    bpBased = 1'b1; offset = 16'h0042; checkOut("R9 bp high");
    bpBased = 1'b0; checkOut("R9 bp low");
    endInst();

    done = 1;
    report();
  end

endmodule